// File: doc/BRIEF.md
# Sleep Timer With Rollover Watchdog

This block keeps a free-running sleep counter that advances on each slow-clock tick. It wraps at one of four power-of-two periods. Each wrap raises a sleep event. The event latches into a pending flag, and the sleep interrupt is that flag qualified by a mask bit held in a small register.

The watchdog keeps no time base of its own. It counts the wraps of the sleep counter. On the third wrap since it was last serviced, it raises a reset request for one clock. Software services it through a write-only clear register. Any data value written there clears only the wrap count, so the sleep counter keeps running. One special value clears the wrap count and the sleep counter together.

Servicing only the watchdog therefore leaves between two and three sleep periods before the next reset request. The exact figure depends on how far the sleep counter had advanced. The special value gives a full three periods.

Top module: `slp_wdog`

## Requirements
- R1: The sleep counter advances only in clock cycles where `tick` is 1, and it wraps after 2^(6+3*`interval_sel`) ticks (64, 512, 4096 or 32768). Each wrap is a rollover event.
- R2: A rollover sets a pending flag, and `sleep_irq` equals the pending flag ANDed with mask bit 6. The flag holds until `pend_clr` is 1 in a cycle with no rollover; a rollover in the same cycle wins.
- R3: The mask register is at `bus_addr`=0. It keeps only data bit 6 and reads back as 8'h40 when that bit is set, 8'h00 otherwise.
- R4: The clear register is at `bus_addr`=1 and always reads 8'h00.
- R5: A write of any value other than 8'h38 to the clear register zeroes the watchdog wrap count and leaves the sleep counter running.
- R6: A write of 8'h38 to the clear register zeroes the wrap count and the sleep counter in the same cycle. A rollover due in that cycle does not occur.
- R7: `wd_reset` is 1 for exactly one cycle, in the cycle after the third counted rollover since the last clear, and the wrap count then restarts from zero.
- R8: A clear-register write in the same cycle as a rollover wins: that rollover is not counted by the watchdog, though it still sets the pending flag.
- R9: While `wd_en` is 0 the wrap count is held at zero and `wd_reset` stays 0. Counting starts afresh once `wd_en` is 1.
- R10: After reset, `wd_reset`, `sleep_irq` and the mask register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow-clock enable, one cycle per tick |
| interval_sel | input | 2 | Sleep period select |
| wd_en | input | 1 | Watchdog enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mask, 1 clear |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| pend_clr | input | 1 | Clears the sleep pending flag |
| sleep_irq | output | 1 | Masked sleep interrupt |
| wd_reset | output | 1 | One-cycle watchdog reset request |

## Verification
A sleep counter holding a wrong value shows up at the first rollover it should have made. `sleep_irq` rises a cycle early or late, or not at all, so the error appears within one sleep period. A wrong wrap count appears only at the next watchdog expiry. `wd_reset` then lands one period early or late, up to three periods after the fault, so the bench places clears right before, at, and right after a rollover edge. A corrupted pending flag or mask bit appears at once on `sleep_irq`, and a corrupted mask bit also appears on `bus_rdata`.

// File: rtl/slp_wdog.sv
module slp_wdog #(
  parameter int         BASE_LOG2 = 6,
  parameter int         STEP_LOG2 = 3,
  parameter int         IRQ_BIT   = 6,
  parameter logic [7:0] MAGIC     = 8'h38
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] interval_sel,
  input  logic       wd_en,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       pend_clr,
  output logic       sleep_irq,
  output logic       wd_reset
);
  localparam int CW = BASE_LOG2 + 3 * STEP_LOG2;
  localparam int SW = $clog2(CW + 1);

  logic [CW-1:0] sl_cnt;
  logic [CW-1:0] wrap_mask;
  logic [SW-1:0] shamt;
  logic [1:0]    wd_cnt;
  logic          msk_q, pend_q, rst_q;

  wire clr_hit = bus_wr & bus_addr;
  wire magic   = clr_hit & (bus_wdata == MAGIC);
  wire msk_wr  = bus_wr & ~bus_addr;

  assign shamt     = SW'(BASE_LOG2) + SW'(STEP_LOG2) * SW'(interval_sel);
  assign wrap_mask = ({{(CW-1){1'b0}}, 1'b1} << shamt) - {{(CW-1){1'b0}}, 1'b1};

  wire roll = tick & ~magic & ((sl_cnt & wrap_mask) == wrap_mask);

  always_ff @(posedge clk) begin
    if (!rst_n)     sl_cnt <= '0;
    else if (magic) sl_cnt <= '0;
    else if (roll)  sl_cnt <= '0;
    else if (tick)  sl_cnt <= sl_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_cnt <= '0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (!wd_en || clr_hit) begin
        wd_cnt <= '0;
      end else if (roll) begin
        if (wd_cnt == 2'd2) begin
          wd_cnt <= '0;
          rst_q  <= 1'b1;
        end else begin
          wd_cnt <= wd_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (roll)     pend_q <= 1'b1;
    else if (pend_clr) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      msk_q <= 1'b0;
    else if (msk_wr) msk_q <= bus_wdata[IRQ_BIT];
  end

  assign bus_rdata = bus_addr ? 8'h00 : (8'(msk_q) << IRQ_BIT);
  assign sleep_irq = pend_q & msk_q;
  assign wd_reset  = rst_q;
endmodule

module slp_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wd_en,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       pend_clr,
  input logic       sleep_irq,
  input logic       wd_reset
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wd_reset |=> !wd_reset); // R7
  AST_WD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wd_en |=> !wd_reset); // R9
  AST_CLR_NO_RST: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr) |=> !wd_reset); // R5
  AST_MAGIC_NO_ROLL: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr && bus_wdata == 8'h38) |=> !$rose(sleep_irq)); // R6
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_addr |-> bus_rdata == 8'h00); // R4
  AST_MASK_ONLY_B6: assert property (@(posedge clk) disable iff (!rst_n) !bus_addr |-> (bus_rdata & 8'hBF) == 8'h00); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sleep_irq && !pend_clr && !(bus_wr && !bus_addr)) |=> sleep_irq); // R2
endmodule

bind slp_wdog slp_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_clr(pend_clr),
  .sleep_irq(sleep_irq), .wd_reset(wd_reset)
);

// File: tb/slp_wdog_bench.sv
`timescale 1ns/1ps
module slp_wdog_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wd_en = 1'b0;
  logic [1:0] interval_sel = 2'd0;
  logic bus_wr = 1'b0, bus_addr = 1'b0, pend_clr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic sleep_irq, wd_reset;

  slp_wdog u_slp_wdog (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int sig; logic val; string req; } item_t;
  item_t q[$];
  int total = 0, bad = 0, base = 0;
  bit done = 1'b0;

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic expect_at(int due, int sig, logic val, string req);
    q.push_back('{due, sig, val, req});
  endtask

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        check(q[i].req, q[i].sig == 0 ? int'(wd_reset) : int'(sleep_irq), int'(q[i].val));
        q.delete(i);
      end
    end
  end

  task automatic wait_until(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic reg_write(logic a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic magic_clear();
    base = cyc;
    bus_addr = 1'b1; bus_wdata = 8'h38; bus_wr = 1'b1; pend_clr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pend_clr = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 wd_reset", wd_reset, 0);
    check("R10 sleep_irq", sleep_irq, 0);
    check("R10 mask", bus_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1; tick = 1'b1;
    @(negedge clk);

    reg_write(1'b0, 8'hFF); #1;
    check("R3 mask keeps bit6", bus_rdata, 8'h40);
    bus_addr = 1'b1; #1;
    check("R4 clear reads zero", bus_rdata, 8'h00);
    @(negedge clk);
    reg_write(1'b0, 8'hBF); #1;
    check("R3 mask other bits", bus_rdata, 8'h00);
    @(negedge clk);
    reg_write(1'b0, 8'h40);

    // full three-interval timeout after 0x38
    wd_en = 1'b1;
    magic_clear();
    expect_at(base + 64, 1, 1'b0, "R1 before wrap");
    expect_at(base + 65, 1, 1'b1, "R1 wrap at 64");
    expect_at(base + 65, 0, 1'b0, "R7 not first roll");
    expect_at(base + 192, 0, 1'b0, "R7 before third");
    expect_at(base + 193, 0, 1'b1, "R7 third roll");
    expect_at(base + 194, 0, 1'b0, "R7 one cycle");
    wait_until(base + 200);

    // plain clear one edge before a rollover: ~two intervals
    magic_clear();
    wait_until(base + 63);
    reg_write(1'b1, 8'h11);
    expect_at(base + 129, 0, 1'b0, "R5 second roll");
    expect_at(base + 193, 0, 1'b1, "R5 sleep kept running");
    wait_until(base + 200);

    // plain clear coincident with rollover
    magic_clear();
    wait_until(base + 64);
    reg_write(1'b1, 8'h5A);
    expect_at(base + 65, 1, 1'b1, "R8 pending still set");
    expect_at(base + 193, 0, 1'b0, "R8 roll not counted");
    expect_at(base + 257, 0, 1'b1, "R8 reset one later");
    wait_until(base + 260);

    // 0x38 coincident with rollover
    magic_clear();
    wait_until(base + 64);
    magic_clear();
    expect_at(base + 1, 1, 1'b0, "R6 roll suppressed");
    expect_at(base + 64, 1, 1'b0, "R6 counter zeroed");
    expect_at(base + 65, 1, 1'b1, "R6 wrap from zero");
    wait_until(base + 70);

    // watchdog disabled
    wd_en = 1'b0;
    magic_clear();
    expect_at(base + 193, 0, 1'b0, "R9 disabled third");
    expect_at(base + 257, 0, 1'b0, "R9 disabled fourth");
    wait_until(base + 260);
    wd_en = 1'b1;
    expect_at(base + 385, 0, 1'b0, "R9 restart second");
    expect_at(base + 449, 0, 1'b1, "R9 restart third");
    wait_until(base + 450);
    wd_en = 1'b0;

    // tick gating
    magic_clear();
    wait_until(base + 10);
    tick = 1'b0;
    wait_until(base + 110);
    tick = 1'b1;
    expect_at(base + 164, 1, 1'b0, "R1 no count without tick");
    expect_at(base + 165, 1, 1'b1, "R1 delayed wrap");
    wait_until(base + 166);

    // pending flag and masking
    #1 check("R2 pending", sleep_irq, 1);
    @(negedge clk);
    reg_write(1'b0, 8'h00); #1;
    check("R2 masked off", sleep_irq, 0);
    @(negedge clk);
    reg_write(1'b0, 8'h40); #1;
    check("R2 pending kept under mask", sleep_irq, 1);
    @(negedge clk);
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0; #1;
    check("R2 pend_clr", sleep_irq, 0);
    @(negedge clk);

    for (int s = 1; s < 4; s++) begin
      int p;
      p = 64 << (3 * s);
      interval_sel = 2'(s);
      magic_clear();
      expect_at(base + p, 1, 1'b0, "R1 long interval before");
      expect_at(base + p + 1, 1, 1'b1, "R1 long interval wrap");
      wait_until(base + p + 2);
    end

    repeat (2) @(negedge clk);
    total += q.size();
    bad += q.size();
    if (q.size() != 0) $display("FAIL scoreboard: actual=%0d left expected=0", q.size());
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule